// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sequences the control strobes of a processor-side bus whose address and data share the same pins. It takes one request at a time from a valid/ready handshake. Each request carries an address, write data, a write flag and an I/O flag. The block turns each request into a four-state bus cycle (T1 to T4). During the cycle it drives the shared pins, the address latch pulse, the read and write strobes, the memory versus I/O select, and the direction and enable of the external data transceivers. For reads, the byte returned on the shared pins is handed back on a one-cycle response.

A slow target holds the cycle by keeping the ready input low. Wait states are then inserted after T3. An external master can take the bus through a hold request. The block grants it only between cycles. While the hold is granted, the strobe group is released to high impedance, and the latch pulse stays driven low. A synchronous reset ends any cycle in progress. Once reset is released, the block issues its own first fetch: a memory read at the reset vector, before it accepts any request.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While `rst` is high, the outputs show the idle state: `rd_n`=1, `wr_n`=1, `ale`=0, `xcvr_en`=0, `ad_oe`=0, `hold_ack`=0, `req_ready`=0, `ctl_oe`=1. A cycle in progress is abandoned at the first clock edge that sees `rst` high.
- R2: In the clock after the first edge that sees `rst` low, and if no hold is requested, the block starts a memory read (`io_sel`=0, `dir_tx`=0) at `RESET_VEC` (default 0xFFFF0). It does this before any request is accepted.
- R3: A cycle runs T1, T2, T3, then zero or more wait states, then T4, with one clock per state. `ale` is high for exactly the T1 clock, and `ad_o` then carries the full address with `ad_oe`=1. Reads drive `rd_n` low and writes drive `wr_n` low from T2 through the last T3 or wait state. Both strobes are high in T1 and T4, and they are never low together. The address captured by the falling edge of `ale` equals the request address.
- R4: From T1 to T4, `io_sel` is 1 for I/O and 0 for memory, and `dir_tx` is 1 for writes and 0 for reads. Both stay constant across that span.
- R5: `xcvr_en` is 0 in T1, while the pins carry the address. It is 1 from T2 through the last T3 or wait state for reads, and from T2 through T4 for writes.
- R6: `ready` is sampled at the clock edge that ends T3 and at the edge that ends each wait state. A low sample adds one more wait state, with the active strobe held low and no response given.
- R7: For reads, `ad_i` is captured at the edge where `ready` is seen high. It is presented on `rsp_data`, with `rsp_valid`=1 for the T4 clock only.
- R8: For writes, `ad_o` carries the write data zero-extended to the address width, and `ad_oe`=1 from T2 to T4. For reads, `ad_oe`=0 from T2 to T4.
- R9: `req_ready` is 1 in idle or T4 when `hold_req` is low and the reset fetch is done. An accepted request enters T1 at the next clock, so back-to-back cycles run with no idle clock between them.
- R10: `hold_req` is honoured only in idle or T4, and it beats a request presented in the same clock. `hold_ack` rises at the next clock and falls one clock after `hold_req` is sampled low.
- R11: While `hold_ack` is 1: `ctl_oe`=0, so `rd_n`, `wr_n`, `io_sel` and `dir_tx` float; `ad_oe`=0; `xcvr_en`=0; and `ale`, which has no enable, stays driven at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| rsp_valid | output | 1 | Read data valid (T4 of a read) |
| rsp_data | output | DW | Read data |
| ready | input | 1 | Target ready; low inserts wait states |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus granted to external master |
| ad_o | output | AW | Shared address/data pins, output value |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ad_i | input | DW | Shared pins, input value (low byte) |
| ale | output | 1 | Address latch pulse; falling edge captures the address |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| dir_tx | output | 1 | Transceiver direction, 1 = drive out |
| ctl_oe | output | 1 | Drive enable for `rd_n`, `wr_n`, `io_sel`, `dir_tx` |
| xcvr_en | output | 1 | Transceiver enable, active high |

## Verification
The case that needs care is a hold request that lands on the same clock as the end of a cycle or as a new request. Only one of them can win, and a wrong choice would cut a cycle short or start a T1 during the grant. The bench raises `hold_req` in the middle of a cycle and checks three things: the cycle still runs through T4, `req_ready` stays low in that T4, and `hold_ack` rises in the very next clock. A separate case presents `hold_req` and `req_valid` together in idle. There, the floated outputs and the absence of an `ale` pulse show that the grant came first, and the held request must enter T1 only after `hold_ack` falls.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } bus_st_e;

  typedef struct packed {
    logic ale;
    logic rd_n;
    logic wr_n;
    logic io_sel;
    logic dir_tx;
    logic xcvr_en;
    logic ad_oe;
    logic ctl_oe;
  } strobe_t;

  // idle or last state of a cycle: the only places a new owner may take over
  function automatic logic at_boundary(bus_st_e s);
    return (s == ST_IDLE) || (s == ST_T4);
  endfunction

  // states where the selected strobe is low
  function automatic logic strobe_low(bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // states after the address phase of a running cycle
  function automatic logic data_phase(bus_st_e s);
    return strobe_low(s) || (s == ST_T4);
  endfunction

  function automatic bus_st_e step(bus_st_e s, logic hold_req, logic start, logic ready);
    bus_st_e n;
    case (s)
      ST_IDLE, ST_T4: begin
        if (hold_req)   n = ST_HOLD;
        else if (start) n = ST_T1;
        else            n = ST_IDLE;
      end
      ST_T1:          n = ST_T2;
      ST_T2:          n = ST_T3;
      ST_T3, ST_TW:   n = ready ? ST_T4 : ST_TW;
      ST_HOLD:        n = hold_req ? ST_HOLD : ST_IDLE;
      default:        n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic strobe_t decode(bus_st_e s, logic wr, logic io);
    strobe_t r;
    r = '0;
    r.rd_n   = 1'b1;
    r.wr_n   = 1'b1;
    r.ctl_oe = 1'b1;
    case (s)
      ST_T1: begin
        r.ale    = 1'b1;
        r.io_sel = io;
        r.dir_tx = wr;
        r.ad_oe  = 1'b1;
      end
      ST_T2, ST_T3, ST_TW: begin
        r.io_sel  = io;
        r.dir_tx  = wr;
        r.rd_n    = wr;
        r.wr_n    = ~wr;
        r.xcvr_en = 1'b1;
        r.ad_oe   = wr;
      end
      ST_T4: begin
        r.io_sel  = io;
        r.dir_tx  = wr;
        r.xcvr_en = wr;
        r.ad_oe   = wr;
      end
      ST_HOLD: r.ctl_oe = 1'b0;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    hold_req,
  input  logic    ready,
  output bus_st_e st,
  output logic    req_ready,
  output logic    cyc_start,
  output logic    use_boot,
  output logic    rd_capture,
  output logic    hold_grant
);

  logic    boot_pend;
  logic    go;
  bus_st_e st_nxt;

  assign go         = at_boundary(st) && !hold_req;
  assign use_boot   = go && boot_pend;
  assign req_ready  = go && !boot_pend;
  assign cyc_start  = go && (boot_pend || req_valid);
  assign hold_grant = at_boundary(st) && hold_req;
  assign rd_capture = ((st == ST_T3) || (st == ST_TW)) && ready;

  always_comb begin
    st_nxt = step(st, hold_req, boot_pend || req_valid, ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      boot_pend <= 1'b1;
    end else begin
      st <= st_nxt;
      if (use_boot) boot_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/mbus_cyc_regs.sv
module mbus_cyc_regs #(
  parameter int             AW        = 20,
  parameter int             DW        = 8,
  parameter logic [AW-1:0]  RESET_VEC = AW'(20'hFFFF0)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic          use_boot,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wr,
  input  logic          req_io,
  input  logic          rd_capture,
  input  logic [DW-1:0] ad_i,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          cur_wr,
  output logic          cur_io,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_wr    <= 1'b0;
      cur_io    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (cyc_start) begin
        if (use_boot) begin
          cur_addr  <= RESET_VEC;
          cur_wdata <= '0;
          cur_wr    <= 1'b0;
          cur_io    <= 1'b0;
        end else begin
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          cur_wr    <= req_wr;
          cur_io    <= req_io;
        end
      end
      if (rd_capture && !cur_wr) rsp_data <= ad_i;
    end
  end

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  bus_st_e       st,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  input  logic          cur_wr,
  input  logic          cur_io,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_sel,
  output logic          dir_tx,
  output logic          ctl_oe,
  output logic          xcvr_en,
  output logic          hold_ack,
  output logic          rsp_valid
);

  strobe_t s;

  always_comb begin
    s = decode(st, cur_wr, cur_io);
  end

  assign ale       = s.ale;
  assign rd_n      = s.rd_n;
  assign wr_n      = s.wr_n;
  assign io_sel    = s.io_sel;
  assign dir_tx    = s.dir_tx;
  assign ctl_oe    = s.ctl_oe;
  assign xcvr_en   = s.xcvr_en;
  assign ad_oe     = s.ad_oe;
  assign hold_ack  = (st == ST_HOLD);
  assign rsp_valid = (st == ST_T4) && !cur_wr;

  always_comb begin
    ad_o = '0;
    if (st == ST_T1)                   ad_o = cur_addr;
    else if (cur_wr && data_phase(st)) ad_o = AW'(cur_wdata);
  end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int            AW        = 20,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] RESET_VEC = AW'(20'hFFFF0)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wr,
  input  logic          req_io,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          ready,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_sel,
  output logic          dir_tx,
  output logic          ctl_oe,
  output logic          xcvr_en
);

  bus_st_e       st;
  logic          cyc_start;
  logic          use_boot;
  logic          rd_capture;
  logic          hold_grant;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          cur_wr;
  logic          cur_io;

  // named events for the checker
  logic in_data;
  logic in_t3w;
  assign in_data = data_phase(st);
  assign in_t3w  = (st == ST_T3) || (st == ST_TW);

  mbus_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .hold_req   (hold_req),
    .ready      (ready),
    .st         (st),
    .req_ready  (req_ready),
    .cyc_start  (cyc_start),
    .use_boot   (use_boot),
    .rd_capture (rd_capture),
    .hold_grant (hold_grant)
  );

  mbus_cyc_regs #(.AW(AW), .DW(DW), .RESET_VEC(RESET_VEC)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cyc_start  (cyc_start),
    .use_boot   (use_boot),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_wr     (req_wr),
    .req_io     (req_io),
    .rd_capture (rd_capture),
    .ad_i       (ad_i),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .cur_wr     (cur_wr),
    .cur_io     (cur_io),
    .rsp_data   (rsp_data)
  );

  mbus_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .st        (st),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .cur_wr    (cur_wr),
    .cur_io    (cur_io),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_sel    (io_sel),
    .dir_tx    (dir_tx),
    .ctl_oe    (ctl_oe),
    .xcvr_en   (xcvr_en),
    .hold_ack  (hold_ack),
    .rsp_valid (rsp_valid)
  );

endmodule

// File: rtl/mbus_bus_checker.sv
module mbus_bus_checker #(
  parameter int            AW        = 20,
  parameter logic [AW-1:0] RESET_VEC = AW'(20'hFFFF0)
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          io_sel,
  input logic          dir_tx,
  input logic          xcvr_en,
  input logic          ad_oe,
  input logic          ctl_oe,
  input logic          hold_ack,
  input logic          hold_req,
  input logic          ready,
  input logic [AW-1:0] ad_o,
  input logic          cyc_start,
  input logic          hold_grant,
  input logic          in_data,
  input logic          in_t3w
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R3

  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R3

  AST_START_ALE: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> ale); // R3

  AST_ADDR_NO_XCVR: assert property (@(posedge clk) disable iff (rst)
    ale |-> (!xcvr_en && ad_oe)); // R5

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    in_data |-> ($stable(io_sel) && $stable(dir_tx))); // R4

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_t3w && !ready) |=> (in_t3w && $stable(rd_n) && $stable(wr_n))); // R6

  AST_HOLD_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_grant)); // R10

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> !hold_ack); // R10

  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!ctl_oe && !ad_oe && !ale && !xcvr_en)); // R11

  AST_BOOT_FETCH: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !hold_req) |=> (ale && (ad_o == RESET_VEC) && !io_sel && !dir_tx)); // R2

endmodule

bind mbus_cycle_ctrl mbus_bus_checker #(.AW(AW), .RESET_VEC(RESET_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .io_sel     (io_sel),
  .dir_tx     (dir_tx),
  .xcvr_en    (xcvr_en),
  .ad_oe      (ad_oe),
  .ctl_oe     (ctl_oe),
  .hold_ack   (hold_ack),
  .hold_req   (hold_req),
  .ready      (ready),
  .ad_o       (ad_o),
  .cyc_start  (cyc_start),
  .hold_grant (hold_grant),
  .in_data    (in_data),
  .in_t3w     (in_t3w)
);

// File: tb/mbus_cycle_ctrl_test.sv
module mbus_cycle_ctrl_test;
  localparam int            AW = 20;
  localparam int            DW = 8;
  localparam logic [AW-1:0] RV = 20'hFFFF0;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_wr, req_io;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          ready, hold_req, hold_ack;
  logic [AW-1:0] ad_o;
  logic          ad_oe;
  logic [DW-1:0] ad_i;
  logic          ale, rd_n, wr_n, io_sel, dir_tx, ctl_oe, xcvr_en;
  logic [AW-1:0] lat;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mbus_cycle_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wr(req_wr), .req_io(req_io),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ready(ready),
    .hold_req(hold_req), .hold_ack(hold_ack), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
    .dir_tx(dir_tx), .ctl_oe(ctl_oe), .xcvr_en(xcvr_en)
  );

  // external address latch: transparent while ale is high, holds after its fall
  always @(posedge clk) if (ale === 1'b1) lat <= ad_o;

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_checks(input string tag);
    eq({tag, " rd_n"}, rd_n, 1);
    eq({tag, " wr_n"}, wr_n, 1);
    eq({tag, " ale"}, ale, 0);
    eq({tag, " xcvr_en"}, xcvr_en, 0);
    eq({tag, " ad_oe"}, ad_oe, 0);
    eq({tag, " ctl_oe"}, ctl_oe, 1);
  endtask

  task automatic hold_checks(input string tag);
    eq({tag, " hold_ack"}, hold_ack, 1);
    eq({tag, " ctl_oe float"}, ctl_oe, 0);
    eq({tag, " ad_oe"}, ad_oe, 0);
    eq({tag, " ale driven low"}, ale, 0);
    eq({tag, " xcvr_en"}, xcvr_en, 0);
    eq({tag, " req_ready"}, req_ready, 0);
  endtask

  // called at a falling edge; returns at the falling edge inside T4
  task automatic run_cycle(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic w, input logic io, input int waits,
                           input logic [DW-1:0] rdv, input logic hold_mid);
    logic [AW-1:0] wexp;
    wexp = AW'(wd);
    while (req_ready !== 1'b1) @(negedge clk);
    req_valid = 1; req_addr = a; req_wdata = wd; req_wr = w; req_io = io;
    @(negedge clk);
    req_valid = 0;
    eq("R3 T1 ale", ale, 1);
    eq("R3 T1 address on pins", ad_o, a);
    eq("R3 T1 ad_oe", ad_oe, 1);
    eq("R5 T1 xcvr_en off", xcvr_en, 0);
    eq("R4 T1 io_sel", io_sel, io);
    eq("R4 T1 dir_tx", dir_tx, w);
    eq("R3 T1 strobes high", {rd_n, wr_n}, 2'b11);
    @(negedge clk);
    if (hold_mid) hold_req = 1;
    ad_i = rdv;
    eq("R3 T2 rd_n", rd_n, w);
    eq("R3 T2 wr_n", wr_n, !w);
    eq("R5 T2 xcvr_en", xcvr_en, 1);
    eq("R3 T2 latched address", lat, a);
    eq("R8 T2 ad_oe", ad_oe, w);
    if (w) eq("R8 T2 write data", ad_o, wexp);
    eq("R10 T2 no grant mid-cycle", hold_ack, 0);
    @(negedge clk);
    ready = (waits == 0);
    eq("R3 T3 strobe low", w ? wr_n : rd_n, 0);
    eq("R4 T3 io_sel", io_sel, io);
    eq("R7 T3 no response", rsp_valid, 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      ready = (i == waits - 1);
      eq("R6 wait strobe held", w ? wr_n : rd_n, 0);
      eq("R6 wait no response", rsp_valid, 0);
      eq("R5 wait xcvr_en", xcvr_en, 1);
      eq("R3 wait latched address", lat, a);
    end
    @(negedge clk);
    ready = 1;
    eq("R3 T4 strobes high", {rd_n, wr_n}, 2'b11);
    eq("R5 T4 xcvr_en", xcvr_en, w);
    eq("R7 T4 rsp_valid", rsp_valid, !w);
    if (!w) eq("R7 T4 rsp_data", rsp_data, rdv);
    if (w) eq("R8 T4 write data", ad_o, wexp);
    eq("R4 T4 io_sel", io_sel, io);
    eq("R4 T4 dir_tx", dir_tx, w);
    eq("R3 T4 latched address", lat, a);
    eq("R10 T4 no grant yet", hold_ack, 0);
    eq("R9 T4 req_ready", req_ready, !hold_mid);
  endtask

  task automatic boot_check(input logic [DW-1:0] rdv);
    ad_i = rdv; ready = 1;
    @(negedge clk);
    eq("R2 boot ale", ale, 1);
    eq("R2 boot address", ad_o, RV);
    eq("R2 boot memory", io_sel, 0);
    eq("R2 boot read", dir_tx, 0);
    eq("R2 no request accepted", req_ready, 0);
    @(negedge clk);
    eq("R2 boot rd_n", rd_n, 0);
    @(negedge clk);
    @(negedge clk);
    eq("R2 boot rsp_valid", rsp_valid, 1);
    eq("R2 boot rsp_data", rsp_data, rdv);
    eq("R2 boot latched address", lat, RV);
    eq("R9 ready after boot", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_addr = '0; req_wdata = '0; req_wr = 0; req_io = 0;
    ready = 1; hold_req = 0; ad_i = '0;
    repeat (3) @(negedge clk);
    idle_checks("R1 reset");
    eq("R1 reset hold_ack", hold_ack, 0);
    eq("R1 reset req_ready", req_ready, 0);
    rst = 0;
    boot_check(8'h5A);

    // sweep: memory/io x read/write x wait counts, back to back (R9)
    for (int t = 0; t < 4; t++)
      for (int wt = 0; wt < 3; wt++)
        for (int k = 0; k < 2; k++) begin
          logic [AW-1:0] a;
          a = AW'(20'h12345 + t * 20'h1111 + wt * 20'h0F0F + k * 20'h80000);
          run_cycle(a, DW'(8'hA0 + t * 16 + wt * 4 + k), t[0], t[1], wt,
                    DW'(8'h3C ^ (t * 8 + wt * 2 + k)), 1'b0);
        end

    // hold raised mid-cycle: granted only after T4 (R10, R11)
    run_cycle(20'h0ABCD, 8'h11, 1'b1, 1'b0, 0, 8'h00, 1'b1);
    req_valid = 1; req_addr = 20'h0F00D; req_wdata = 8'h00; req_wr = 0; req_io = 1;
    @(negedge clk);
    hold_checks("R11 hold after cycle");
    @(negedge clk);
    hold_checks("R11 hold persists");
    hold_req = 0;
    @(negedge clk);
    eq("R10 hold dropped", hold_ack, 0);
    idle_checks("R10 after hold");
    eq("R10 request resumes", req_ready, 1);
    run_cycle(20'h0F00D, 8'h00, 1'b0, 1'b1, 1, 8'h77, 1'b0);

    // hold and request together in idle: hold wins (R10)
    @(negedge clk);
    req_valid = 1; req_addr = 20'h44444; req_wr = 0; req_io = 0;
    hold_req = 1;
    #1 eq("R10 collision req_ready", req_ready, 0);
    @(negedge clk);
    hold_checks("R10 collision grant");
    hold_req = 0;
    @(negedge clk);
    eq("R10 collision release", hold_ack, 0);
    run_cycle(20'h44444, 8'h00, 1'b0, 1'b0, 0, 8'h99, 1'b0);

    // reset in the middle of a write aborts it and re-issues the boot fetch (R1, R2)
    @(negedge clk);
    req_valid = 1; req_addr = 20'h22222; req_wdata = 8'hEE; req_wr = 1; req_io = 0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    eq("R3 abort target wr_n low", wr_n, 0);
    rst = 1;
    @(negedge clk);
    idle_checks("R1 abort");
    eq("R1 abort req_ready", req_ready, 0);
    rst = 0;
    boot_check(8'hC3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule